// File: doc/BRIEF.md
# Looping Audio Sample DMA

This block runs a streaming DMA that feeds audio samples from main memory and loops over the same buffer without end. Software sets a 32-bit buffer start address through two 16-bit registers. It then writes a control word that holds an enable bit and a length in blocks. One block is 32 bytes, which is eight stereo pairs of 16-bit samples. The audio output side pulses a tick input once per block it consumes. For each accepted tick the controller issues a fetch strobe with the block address and then moves on by one block.

When the last block of the buffer has been consumed, the live address and the live count reload from the programmed registers and an interrupt request pulses. Software therefore rewrites the start and length registers while the transfer runs, and the new values take effect at the next wrap. A read-only register reports the blocks left in zero-based form. A second interrupt request pulses a fixed number of cycles after the controller is switched on. An external reset strobe from the sample processor clears the control register.

Top module: `audio_loop_dma`

## Requirements
- R1: The register port selects by `wr_sel`/`rd_sel`: 0 is start address bits 31:16, 1 is start address bits 15:0, 2 is the control word (bit 15 enable, bits 14:0 block count), and 3 is the read-only blocks-left value. `rd_data` shows the selected register in the same cycle.
- R2: A control write that sets bit 15 while enable is 0 loads the live address from the start registers and the live count from the count field of that write.
- R3: While enabled, writes to the start registers or the control word leave the live address and live count alone. The values they write are used at the next wrap.
- R4: A tick seen while enabled gives `fetch_strobe` high for exactly the next cycle, with `fetch_addr` equal to the live address before the tick. If the live count was nonzero, it drops by one and the live address rises by 32.
- R5: If the live count is zero after such a tick, the live address and count reload from the start registers and the control count, and `irq_req` is high in the same cycle as the strobe. With a count of 0, every tick raises `irq_req` and fetches the start address.
- R6: Reading select 3 returns the live count minus one when the count is nonzero and 0 when it is zero. Writes to select 3 change nothing.
- R7: After an enabling write (see R2) is sampled at a clock edge, `irq_req` is high for one cycle after the 200th following edge and low after each of the 199 edges before it, as long as no tick wraps in that window.
- R8: While enable is 0, ticks produce no strobe and no interrupt, and they leave the live count unchanged.
- R9: A `dsp_reset` pulse clears the whole control word and wins over a control write in the same cycle. It leaves the start address registers unchanged.
- R10: After `rst` all registers read 0 and `fetch_strobe` and `irq_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for writes |
| wr_data | input | 16 | Register write data |
| rd_sel | input | 2 | Register select for reads |
| rd_data | output | 16 | Selected register value |
| blk_tick | input | 1 | One pulse per consumed 32-byte block |
| dsp_reset | input | 1 | Clears the control register |
| fetch_strobe | output | 1 | One-cycle pulse per fetched block |
| fetch_addr | output | 32 | Byte address of the fetched block |
| irq_req | output | 1 | One-cycle audio interrupt request |

## Verification
The bench uses the default parameters: a 15-bit block count, 32-byte blocks and a 200-cycle start interrupt delay. This lets it check the exact edge on which the start interrupt fires, and check that it is absent on each of the 199 edges before it. A count of 3 makes a wrap happen every third tick, so a vector table can walk several full loops. During those loops it also rewrites the start and count registers and shows that the new values apply only at the next wrap. A count of 0 checks the case where every tick wraps.

// File: rtl/audio_loop_dma_pkg.sv
package audio_loop_dma_pkg;

    localparam int HALF_W = 16;
    localparam int ADDR_W = 2 * HALF_W;

    typedef enum logic [1:0] {
        SEL_START_HI = 2'd0,
        SEL_START_LO = 2'd1,
        SEL_CTRL     = 2'd2,
        SEL_LEFT     = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              enable;
        logic [HALF_W-2:0] count;
    } ctrl_t;

    // Zero-based readback of the live block count.
    function automatic logic [HALF_W-1:0] zero_based_left(input logic [HALF_W-2:0] rem);
        logic [HALF_W-2:0] dec;
        dec = rem - 1'b1;
        return (rem != '0) ? {1'b0, dec} : '0;
    endfunction

endpackage

// File: rtl/audio_loop_dma_regs.sv
module audio_loop_dma_regs
    import audio_loop_dma_pkg::*;
#(
    parameter int CNT_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [HALF_W-1:0] wr_data,
    input  logic              dsp_reset,
    output logic [ADDR_W-1:0] start_addr,
    output ctrl_t             ctrl,
    output logic              load_pulse,
    output logic [CNT_W-1:0]  load_count
);

    logic              ctrl_write;
    logic [HALF_W-2:0] count_field;

    always_comb begin
        ctrl_write = wr_en && (reg_sel_e'(wr_sel) == SEL_CTRL);
        load_pulse = ctrl_write && wr_data[HALF_W-1] && !ctrl.enable && !dsp_reset;
        load_count = wr_data[CNT_W-1:0];
        for (int i = 0; i < HALF_W - 1; i++) begin
            count_field[i] = (i < CNT_W) ? wr_data[i] : 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            start_addr <= '0;
            ctrl       <= '0;
        end else begin
            if (wr_en && (reg_sel_e'(wr_sel) == SEL_START_HI)) begin
                start_addr[ADDR_W-1:HALF_W] <= wr_data;
            end
            if (wr_en && (reg_sel_e'(wr_sel) == SEL_START_LO)) begin
                start_addr[HALF_W-1:0] <= wr_data;
            end
            if (dsp_reset) begin
                ctrl <= '0;
            end else if (ctrl_write) begin
                ctrl.enable <= wr_data[HALF_W-1];
                ctrl.count  <= count_field;
            end
        end
    end

endmodule

// File: rtl/audio_loop_dma_engine.sv
module audio_loop_dma_engine
    import audio_loop_dma_pkg::*;
#(
    parameter int CNT_W       = 15,
    parameter int BLOCK_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [CNT_W-1:0]  load_count,
    input  logic              enable,
    input  logic              tick,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  reload_count,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [CNT_W-1:0]  remaining,
    output logic              fetch_strobe,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              wrap
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BLOCK_BYTES);

    logic              accept;
    logic [CNT_W-1:0]  rem_next;
    logic [ADDR_W-1:0] addr_next;
    logic              wrap_now;

    always_comb begin
        accept    = enable && tick;
        rem_next  = (remaining != '0) ? remaining - 1'b1 : remaining;
        addr_next = (remaining != '0) ? cur_addr + STEP : cur_addr;
        wrap_now  = accept && (rem_next == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_addr     <= '0;
            remaining    <= '0;
            fetch_strobe <= 1'b0;
            fetch_addr   <= '0;
            wrap         <= 1'b0;
        end else begin
            fetch_strobe <= accept;
            wrap         <= wrap_now;
            if (accept) begin
                fetch_addr <= cur_addr;
            end
            if (load) begin
                cur_addr  <= start_addr;
                remaining <= load_count;
            end else if (accept) begin
                if (wrap_now) begin
                    cur_addr  <= start_addr;
                    remaining <= reload_count;
                end else begin
                    cur_addr  <= addr_next;
                    remaining <= rem_next;
                end
            end
        end
    end

endmodule

// File: rtl/audio_loop_dma_timer.sv
module audio_loop_dma_timer #(
    parameter int DELAY = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    output logic fire
);

    localparam int TW = $clog2(DELAY + 1);
    localparam logic [TW-1:0] LOAD_VAL = TW'(DELAY);
    localparam logic [TW-1:0] ONE      = TW'(1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            fire <= 1'b0;
        end else begin
            fire <= !arm && (cnt == ONE);
            if (arm) begin
                cnt <= LOAD_VAL;
            end else if (cnt != '0) begin
                cnt <= cnt - ONE;
            end
        end
    end

endmodule

// File: rtl/audio_loop_dma.sv
module audio_loop_dma
    import audio_loop_dma_pkg::*;
#(
    parameter int CNT_W           = 15,
    parameter int BLOCK_BYTES     = 32,
    parameter int START_IRQ_DELAY = 200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [HALF_W-1:0] wr_data,
    input  logic [1:0]        rd_sel,
    output logic [HALF_W-1:0] rd_data,
    input  logic              blk_tick,
    input  logic              dsp_reset,
    output logic              fetch_strobe,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              irq_req
);

    logic [ADDR_W-1:0] start_addr;
    ctrl_t             ctrl;
    logic              ctrl_en;
    logic              load_pulse;
    logic [CNT_W-1:0]  load_count;
    logic [ADDR_W-1:0] cur_addr;
    logic [CNT_W-1:0]  remaining;
    logic              wrap;
    logic              timer_fire;
    logic [HALF_W-2:0] rem_wide;

    audio_loop_dma_regs #(.CNT_W(CNT_W)) regs_i (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .dsp_reset  (dsp_reset),
        .start_addr (start_addr),
        .ctrl       (ctrl),
        .load_pulse (load_pulse),
        .load_count (load_count)
    );

    audio_loop_dma_engine #(.CNT_W(CNT_W), .BLOCK_BYTES(BLOCK_BYTES)) engine_i (
        .clk          (clk),
        .rst          (rst),
        .load         (load_pulse),
        .load_count   (load_count),
        .enable       (ctrl_en),
        .tick         (blk_tick),
        .start_addr   (start_addr),
        .reload_count (ctrl.count[CNT_W-1:0]),
        .cur_addr     (cur_addr),
        .remaining    (remaining),
        .fetch_strobe (fetch_strobe),
        .fetch_addr   (fetch_addr),
        .wrap         (wrap)
    );

    audio_loop_dma_timer #(.DELAY(START_IRQ_DELAY)) timer_i (
        .clk  (clk),
        .rst  (rst),
        .arm  (load_pulse),
        .fire (timer_fire)
    );

    always_comb begin
        ctrl_en  = ctrl.enable;
        irq_req  = wrap || timer_fire;
        rem_wide = (HALF_W - 1)'(remaining);
        case (reg_sel_e'(rd_sel))
            SEL_START_HI: rd_data = start_addr[ADDR_W-1:HALF_W];
            SEL_START_LO: rd_data = start_addr[HALF_W-1:0];
            SEL_CTRL:     rd_data = ctrl;
            default:      rd_data = zero_based_left(rem_wide);
        endcase
    end

endmodule

// File: rtl/audio_loop_dma_chk.sv
module audio_loop_dma_chk #(
    parameter int CNT_W       = 15,
    parameter int BLOCK_BYTES = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             blk_tick,
    input logic             dsp_reset,
    input logic             en,
    input logic             load,
    input logic [CNT_W-1:0] remaining,
    input logic [31:0]      cur_addr,
    input logic [31:0]      start_addr,
    input logic             fetch_strobe,
    input logic             irq
);

    localparam logic [31:0] STEP = 32'(BLOCK_BYTES);

    AST_LOAD_FROM_START: assert property (@(posedge clk) disable iff (rst)
        load |=> (cur_addr == $past(start_addr))); // R2

    AST_STEP_ADDR: assert property (@(posedge clk) disable iff (rst)
        (en && blk_tick && (remaining > CNT_W'(1))) |=> (cur_addr == $past(cur_addr) + STEP)); // R4

    AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (en && blk_tick && (remaining <= CNT_W'(1))) |=> (irq && (cur_addr == $past(start_addr)))); // R5

    AST_STROBE_GATED: assert property (@(posedge clk) disable iff (rst)
        fetch_strobe |-> $past(en && blk_tick)); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!en && !load) |=> ($stable(remaining) && $stable(cur_addr))); // R8

    AST_DSP_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        dsp_reset |=> !en); // R9

endmodule

bind audio_loop_dma audio_loop_dma_chk #(.CNT_W(CNT_W), .BLOCK_BYTES(BLOCK_BYTES)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .blk_tick     (blk_tick),
    .dsp_reset    (dsp_reset),
    .en           (ctrl_en),
    .load         (load_pulse),
    .remaining    (remaining),
    .cur_addr     (cur_addr),
    .start_addr   (start_addr),
    .fetch_strobe (fetch_strobe),
    .irq          (irq_req)
);

// File: tb/audio_loop_dma_tb_top.sv
`timescale 1ns/1ps
module audio_loop_dma_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = 16'h0;
    logic [1:0]  rd_sel = 2'd0;
    logic [15:0] rd_data;
    logic        blk_tick = 1'b0;
    logic        dsp_reset = 1'b0;
    logic        fetch_strobe;
    logic [31:0] fetch_addr;
    logic        irq_req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    audio_loop_dma dut_i (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_sel       (wr_sel),
        .wr_data      (wr_data),
        .rd_sel       (rd_sel),
        .rd_data      (rd_data),
        .blk_tick     (blk_tick),
        .dsp_reset    (dsp_reset),
        .fetch_strobe (fetch_strobe),
        .fetch_addr   (fetch_addr),
        .irq_req      (irq_req)
    );

    typedef struct packed {
        logic        do_wr;
        logic [1:0]  wsel;
        logic [15:0] wdata;
        logic [31:0] addr;
        logic [15:0] left;
        logic        irq;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 2'd0, 16'h0000, 32'h0012_3400, 16'd1, 1'b0},
        '{1'b0, 2'd0, 16'h0000, 32'h0012_3420, 16'd0, 1'b0},
        '{1'b0, 2'd0, 16'h0000, 32'h0012_3440, 16'd2, 1'b1},
        '{1'b0, 2'd0, 16'h0000, 32'h0012_3400, 16'd1, 1'b0},
        '{1'b0, 2'd0, 16'h0000, 32'h0012_3420, 16'd0, 1'b0},
        '{1'b0, 2'd0, 16'h0000, 32'h0012_3440, 16'd2, 1'b1},
        '{1'b1, 2'd0, 16'h0040, 32'h0012_3400, 16'd1, 1'b0},
        '{1'b1, 2'd1, 16'h0000, 32'h0012_3420, 16'd0, 1'b0},
        '{1'b1, 2'd2, 16'h8002, 32'h0012_3440, 16'd1, 1'b1},
        '{1'b0, 2'd0, 16'h0000, 32'h0040_0000, 16'd0, 1'b0},
        '{1'b0, 2'd0, 16'h0000, 32'h0040_0020, 16'd1, 1'b1}
    };

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [15:0] data);
        rd_sel = sel;
        #1;
        data = rd_data;
    endtask

    task automatic do_tick(input string tag, input logic exp_strobe,
                           input logic [31:0] exp_addr, input logic exp_irq,
                           input logic [15:0] exp_left);
        logic [15:0] v;
        @(negedge clk);
        blk_tick = 1'b1;
        @(negedge clk);
        blk_tick = 1'b0;
        check(tag, "fetch_strobe", {31'b0, fetch_strobe}, {31'b0, exp_strobe});
        if (exp_strobe) check(tag, "fetch_addr", fetch_addr, exp_addr);
        check(tag, "irq_req", {31'b0, irq_req}, {31'b0, exp_irq});
        rd(2'd3, v);
        check(tag, "blocks_left", {16'b0, v}, {16'b0, exp_left});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [15:0] v;
        logic        seen_irq;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R10 reset state
        for (int s = 0; s < 4; s++) begin
            rd(2'(s), v);
            check("R10", "reg after reset", {16'b0, v}, 32'h0);
        end
        check("R10", "fetch_strobe", {31'b0, fetch_strobe}, 32'h0);
        check("R10", "irq_req", {31'b0, irq_req}, 32'h0);

        // R8 tick while disabled
        do_tick("R8", 1'b0, 32'h0, 1'b0, 16'd0);

        // R1 programming and readback
        wr(2'd0, 16'h0012);
        wr(2'd1, 16'h3400);
        wr(2'd2, 16'h8003);
        rd(2'd0, v); check("R1", "start hi", {16'b0, v}, 32'h0012);
        rd(2'd1, v); check("R1", "start lo", {16'b0, v}, 32'h3400);
        rd(2'd2, v); check("R1", "control", {16'b0, v}, 32'h8003);
        rd(2'd3, v); check("R2", "left after enable", {16'b0, v}, 32'd2);

        // R6 write to blocks-left has no effect
        wr(2'd3, 16'hFFFF);
        rd(2'd3, v); check("R6", "left after write", {16'b0, v}, 32'd2);

        // R4 R5 R3 vector walk
        for (int i = 0; i < NVEC; i++) begin
            if (VECS[i].do_wr) wr(VECS[i].wsel, VECS[i].wdata);
            do_tick(i >= 6 ? "R3" : "R4_R5", 1'b1, VECS[i].addr, VECS[i].irq, VECS[i].left);
        end

        // let the pending start interrupt pass
        repeat (250) @(negedge clk);

        // R8 disabled: no strobe, no irq, count held
        wr(2'd2, 16'h0002);
        do_tick("R8", 1'b0, 32'h0, 1'b0, 16'd1);

        // R7 start interrupt timing, with zero count (R5 corner)
        wr(2'd0, 16'h0001);
        wr(2'd1, 16'h0000);
        wr(2'd2, 16'h8000);
        rd(2'd3, v); check("R6", "left with zero count", {16'b0, v}, 32'd0);
        seen_irq = 1'b0;
        for (int k = 1; k < 200; k++) begin
            @(negedge clk);
            if (irq_req) seen_irq = 1'b1;
        end
        check("R7", "irq before 200th edge", {31'b0, seen_irq}, 32'h0);
        @(negedge clk);
        check("R7", "irq at 200th edge", {31'b0, irq_req}, 32'h1);
        @(negedge clk);
        check("R7", "irq after pulse", {31'b0, irq_req}, 32'h0);

        do_tick("R5", 1'b1, 32'h0001_0000, 1'b1, 16'd0);
        do_tick("R5", 1'b1, 32'h0001_0000, 1'b1, 16'd0);

        // R9 dsp reset
        @(negedge clk); dsp_reset = 1'b1;
        @(negedge clk); dsp_reset = 1'b0;
        rd(2'd2, v); check("R9", "control cleared", {16'b0, v}, 32'h0);
        rd(2'd0, v); check("R9", "start hi kept", {16'b0, v}, 32'h0001);
        do_tick("R9", 1'b0, 32'h0, 1'b0, 16'd0);

        // R9 priority over a simultaneous control write
        @(negedge clk);
        dsp_reset = 1'b1; wr_en = 1'b1; wr_sel = 2'd2; wr_data = 16'h8005;
        @(negedge clk);
        dsp_reset = 1'b0; wr_en = 1'b0;
        rd(2'd2, v); check("R9", "reset beats write", {16'b0, v}, 32'h0);
        do_tick("R9", 1'b0, 32'h0, 1'b0, 16'd0);

        // R10 reset mid-run
        wr(2'd2, 16'h8004);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        for (int s = 0; s < 4; s++) begin
            rd(2'(s), v);
            check("R10", "reg after mid-run reset", {16'b0, v}, 32'h0);
        end

        finish_run();
    end

endmodule